// File: doc/BRIEF.md
# Star-Ring Cluster Route Unit

This block chooses the output port and the virtual channel class for packets that enter one core's switch in a cluster. In the cluster, the cores sit on a bidirectional ring and a central hub has a direct link to every core. For each head flit the unit compares the destination core index with the switch's own ring position. A destination one or two ring hops away in either direction stays on the ring, going the short way. A destination farther away is sent to the hub, which delivers it in one more hop. No core is therefore more than two hops from any other core.

The block uses wormhole switching. Only the head flit is routed. Body and tail flits take the port and channel class that the head chose. Deadlock is avoided by splitting the ring into two contiguous halves and giving each half its own channel class. The class is fixed when a packet is injected, from the index of the core that injects it, and it travels unchanged in the head flit after that. All results are registered, so they appear one clock after the flit is presented.

Top module: `starring_route`

## Requirements
- R1: While reset is asserted, and after it until the first valid flit arrives, `out_valid` is 0.
- R2: A head flit whose destination equals `local_id` is routed to the local ejection port (port code 0).
- R3: A head flit whose clockwise distance ((dest - local) mod NCORE) is 1 or 2 is routed clockwise (port code 1).
- R4: A head flit whose clockwise distance is more than 2 and whose counter-clockwise distance ((local - dest) mod NCORE) is 1 or 2 is routed counter-clockwise (port code 2).
- R5: A head flit whose destination is more than two ring hops away in both directions is routed to the hub (port code 3).
- R6: Ring distances wrap around modulo NCORE, so core NCORE-1 and core 0 are neighbours.
- R7: When the destination is exactly two hops away in both directions (NCORE = 4), the clockwise port is chosen.
- R8: For an injected head flit (`in_inject` = 1), the channel class is 0 when `local_id` < NCORE/2 and 1 otherwise, whatever `in_vc_class` holds. For a head flit that is not being injected, the class equals `in_vc_class`.
- R9: A body or tail flit (`in_head` = 0) gets the port and class of the most recent head flit, whatever its own `in_dest`, `in_vc_class` and `in_inject` hold.
- R10: `out_valid`, `out_port` and `out_vc_class` change on the clock edge after the flit is presented. `out_valid` is the value `in_valid` had one cycle earlier, and the port and class hold while no flit is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| local_id | input | IW | Ring position of this switch |
| in_valid | input | 1 | A flit is presented this cycle |
| in_head | input | 1 | The flit is a head flit |
| in_inject | input | 1 | The flit enters the network at this switch |
| in_dest | input | IW | Destination core index from the head flit |
| in_vc_class | input | 1 | Channel class carried in the head flit |
| out_valid | output | 1 | A route result is present |
| out_port | output | 2 | 0 local, 1 clockwise, 2 counter-clockwise, 3 hub |
| out_vc_class | output | 1 | Channel class for the flit |

## Verification
The bench tests the exact two-hop edges from both sides of each switch (distance 2 stays on the ring, distance 3 goes to the hub). If the threshold is off by one, the results show either a three-hop ring path or a needless detour through the hub. It places switches next to the index wrap point. A design that subtracts without taking the modulus sends neighbours across the wrap point to the hub. A separate four-core instance creates a tie, where a design that prefers counter-clockwise shows up at once. Body flits carry misleading destination and class fields, so a unit that re-routes every flit sends the worm's tail down a different path. Injection at both halves of the ring, given a class input that contradicts the expected class, shows whether the class is taken from the source position.

// File: rtl/starring_route.sv
module starring_route #(
  parameter int NCORE = 16,
  parameter int IW    = (NCORE > 2) ? $clog2(NCORE) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] local_id,
  input  logic          in_valid,
  input  logic          in_head,
  input  logic          in_inject,
  input  logic [IW-1:0] in_dest,
  input  logic          in_vc_class,
  output logic          out_valid,
  output logic [1:0]    out_port,
  output logic          out_vc_class
);

  localparam logic [1:0]  P_LOCAL = 2'd0;
  localparam logic [1:0]  P_CW    = 2'd1;
  localparam logic [1:0]  P_CCW   = 2'd2;
  localparam logic [1:0]  P_HUB   = 2'd3;
  localparam logic [IW:0] NC      = (IW+1)'(NCORE);
  localparam logic [IW:0] REACH   = (IW+1)'(2);
  localparam logic [IW-1:0] HALF  = IW'(NCORE / 2);

  logic [IW:0] cw_d, ccw_d;
  logic [1:0]  head_port;
  logic        head_vc;

  assign cw_d  = (in_dest >= local_id) ? ({1'b0, in_dest} - {1'b0, local_id})
                                       : ({1'b0, in_dest} + NC - {1'b0, local_id});
  assign ccw_d = (cw_d == '0) ? '0 : (NC - cw_d);

  always_comb begin
    if (cw_d == '0)          head_port = P_LOCAL;
    else if (cw_d <= REACH)  head_port = P_CW;
    else if (ccw_d <= REACH) head_port = P_CCW;
    else                     head_port = P_HUB;
  end

  assign head_vc = in_inject ? (local_id >= HALF) : in_vc_class;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_port     <= P_LOCAL;
      out_vc_class <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid && in_head) begin
        out_port     <= head_port;
        out_vc_class <= head_vc;
      end
    end
  end

  // R10
  valid_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_port) && $stable(out_vc_class)));

  // R9
  worm_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_head) |=> ($stable(out_port) && $stable(out_vc_class)));

  // R2
  self_eject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_head && in_dest == local_id) |=> (out_port == P_LOCAL));

  // R8
  low_half_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_head && in_inject && local_id < HALF) |=> (out_vc_class == 1'b0));

  // R8
  carried_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_head && !in_inject) |=> (out_vc_class == $past(in_vc_class)));

endmodule

// File: tb/test_starring_route.sv
module test_starring_route;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [3:0] local_id = '0, in_dest = '0;
  logic in_valid = 0, in_head = 0, in_inject = 0, in_vc_class = 0;
  logic out_valid, out_vc_class;
  logic [1:0] out_port;

  logic [1:0] s_local = '0, s_dest = '0;
  logic s_valid = 0, s_head = 0, s_out_valid, s_out_vc;
  logic [1:0] s_out_port;

  int total = 0, bad = 0;
  bit done = 0;

  starring_route #(.NCORE(16)) i_starring_route (
    .clk(clk), .rst_n(rst_n), .local_id(local_id), .in_valid(in_valid),
    .in_head(in_head), .in_inject(in_inject), .in_dest(in_dest),
    .in_vc_class(in_vc_class), .out_valid(out_valid), .out_port(out_port),
    .out_vc_class(out_vc_class));

  starring_route #(.NCORE(4)) i_starring_route_n4 (
    .clk(clk), .rst_n(rst_n), .local_id(s_local), .in_valid(s_valid),
    .in_head(s_head), .in_inject(1'b0), .in_dest(s_dest),
    .in_vc_class(1'b0), .out_valid(s_out_valid), .out_port(s_out_port),
    .out_vc_class(s_out_vc));

  localparam int NV = 15;
  localparam logic [9:0] VEC [NV] = '{
    {4'd3, 4'd3, 2'd0}, {4'd3, 4'd4, 2'd1}, {4'd3, 4'd5, 2'd1},
    {4'd3, 4'd6, 2'd3}, {4'd3, 4'd2, 2'd2}, {4'd3, 4'd1, 2'd2},
    {4'd3, 4'd0, 2'd3}, {4'd15, 4'd0, 2'd1}, {4'd15, 4'd1, 2'd1},
    {4'd0, 4'd15, 2'd2}, {4'd0, 4'd14, 2'd2}, {4'd1, 4'd15, 2'd2},
    {4'd8, 4'd0, 2'd3}, {4'd14, 4'd0, 2'd1}, {4'd0, 4'd13, 2'd3}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic flit(input logic v, input logic h, input logic inj,
                      input logic [3:0] d, input logic vc);
    in_valid = v; in_head = h; in_inject = inj; in_dest = d; in_vc_class = vc;
    @(negedge clk);
  endtask

  function automatic string port_req(input logic [1:0] p);
    case (p)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", out_valid, 0);
    chk("R1", s_out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", out_valid, 0);

    for (int k = 0; k < NV; k++) begin
      local_id = VEC[k][9:6];
      flit(1, 1, 0, VEC[k][5:2], 1'b0);
      chk(port_req(VEC[k][1:0]), out_port, VEC[k][1:0]);
      chk("R10", out_valid, 1);
    end

    // R6: wrap neighbours
    local_id = 4'd15;
    flit(1, 1, 0, 4'd1, 1'b0);
    chk("R6", out_port, 1);
    local_id = 4'd0;
    flit(1, 1, 0, 4'd14, 1'b0);
    chk("R6", out_port, 2);

    // R7: tie on a four-core ring
    s_local = 2'd0; s_dest = 2'd2; s_valid = 1; s_head = 1;
    @(negedge clk);
    chk("R7", s_out_port, 1);
    s_local = 2'd3; s_dest = 2'd1;
    @(negedge clk);
    chk("R7", s_out_port, 1);
    s_valid = 0;

    // R8: class at injection and carried
    local_id = 4'd5;
    flit(1, 1, 1, 4'd6, 1'b1);
    chk("R8", out_vc_class, 0);
    local_id = 4'd12;
    flit(1, 1, 1, 4'd13, 1'b0);
    chk("R8", out_vc_class, 1);
    local_id = 4'd7;
    flit(1, 1, 1, 4'd8, 1'b0);
    chk("R8", out_vc_class, 0);
    local_id = 4'd8;
    flit(1, 1, 1, 4'd9, 1'b0);
    chk("R8", out_vc_class, 1);
    local_id = 4'd2;
    flit(1, 1, 0, 4'd3, 1'b1);
    chk("R8", out_vc_class, 1);

    // R9: worm follows head
    local_id = 4'd3;
    flit(1, 1, 1, 4'd4, 1'b1);
    chk("R9", out_port, 1);
    chk("R9", out_vc_class, 0);
    flit(1, 0, 0, 4'd10, 1'b1);
    chk("R9", out_port, 1);
    chk("R9", out_vc_class, 0);
    flit(1, 0, 1, 4'd3, 1'b1);
    chk("R9", out_port, 1);
    chk("R9", out_vc_class, 0);

    // R10: idle after tail, result held
    flit(0, 1, 0, 4'd3, 1'b1);
    chk("R10", out_valid, 0);
    chk("R10", out_port, 1);
    flit(1, 1, 0, 4'd11, 1'b0);
    chk("R10", out_valid, 1);
    chk("R5", out_port, 3);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule